// File: doc/BRIEF.md
# Fixed-Frame Padding Chunker

This block takes variable-length packets on a 64-bit valid/ready/last stream and puts each one into an output frame of a fixed word count. The frame length is counted in 64-bit words and is loaded from a runtime input. The words of a packet go from input to output unchanged. Once the packet's final word has gone out, the block adds all-ones filler words until the frame has exactly the programmed number of words. The last word of every frame is marked.

The first word of each packet is a header. The packet length in bytes sits in that header, and the block rounds it up to whole words. A packet whose length does not fit in one frame is dropped, and a sticky error flag is raised. While the flag is set, the block accepts and throws away all input and sends nothing. A one-cycle clear pulse lowers the flag, loads a new frame length and makes the block wait for a new header. Packets may arrive back to back, and each one gets its own frame.

Top module: `frame_pad_chunker`

## Requirements
- R1: Every word of a packet that fits leaves the block with its 64-bit value unchanged, in arrival order, starting at word 0 of a new frame.
- R2: Each frame holds exactly the latched frame size in words, and `out_last` is high on the final word of the frame and on no other word.
- R3: After the packet's last word, the rest of the frame is filled with 64'hFFFF_FFFF_FFFF_FFFF, and `in_ready` is low while filler is being sent.
- R4: A packet whose word count equals the frame size gets no filler, and its own last word carries `out_last`.
- R5: The header byte count is taken from header bits [31:16] and rounded up to 64-bit words (a count of zero is taken as one word). If that word count is larger than the frame size, `err` is set and no word of that packet is sent.
- R6: `err` stays set until a clear pulse arrives. While it is set, `out_valid` is low and `in_ready` is high, so incoming words are dropped.
- R7: A one-cycle `clear` pulse lowers `err` in the next cycle, loads `frame_words` as the new frame size (0 is taken as 1), and drops any frame in progress.
- R8: A one-word packet (8 bytes) gives that word followed by frame-size minus one filler words.
- R9: Packets sent back to back each get their own complete frame, with no words lost between them.
- R10: In reset (synchronous, active low), `out_valid` and `err` are low, `in_ready` follows `out_ready`, and `frame_words` is loaded as the frame size.
- R11: While `out_ready` is low during filler, `out_valid` stays high, the filler value is held, and no filler word is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clear | input | 1 | One-cycle pulse: clear error, load frame size |
| frame_words | input | 16 | Frame size in 64-bit words, loaded on reset or clear |
| in_data | input | 64 | Input packet word |
| in_last | input | 1 | Marks the final word of an input packet |
| in_valid | input | 1 | Input word is valid |
| in_ready | output | 1 | Block accepts the input word |
| out_data | output | 64 | Output frame word |
| out_last | output | 1 | Marks the final word of an output frame |
| out_valid | output | 1 | Output word is valid |
| out_ready | input | 1 | Downstream accepts the output word |
| err | output | 1 | Sticky oversize error flag |

## Verification
The case hardest to reach from the ports is backpressure in the middle of filler. In that case the block, not the source, owns the output, so nothing upstream can hold the value. To get there, the stimulus sends a one-word packet into a long frame. It then lowers and raises `out_ready` in a fixed pattern while the filler goes out, and checks the held word and the final frame length. A second hard case is the fault state. A too-long header is sent to enter it, more packets are pushed while the flag is set, and the bench then checks that no output appeared and that a clear brings back normal framing.

// File: rtl/chunk_pkg.sv
// Package: shared state encoding for the padding chunker.
// Assumes: nothing; holds types only.
package chunk_pkg;
    typedef enum logic [1:0] {
        ST_HEAD  = 2'd0,  // waiting for a packet header
        ST_BODY  = 2'd1,  // forwarding packet words after the header
        ST_FILL  = 2'd2,  // sending all-ones filler up to frame end
        ST_FAULT = 2'd3   // oversize seen, dropping input until clear
    } chunk_state_t;
endpackage

// File: rtl/hdr_len_decode.sv
// Module: reads the byte count from a header word, converts it to a word
// count and compares that with the frame size.
// Assumes: the byte count covers the whole packet including the header.
module hdr_len_decode #(
    parameter int DATA_W  = 64,
    parameter int LEN_W   = 16,
    parameter int LEN_LSB = 16
) (
    input  logic [DATA_W-1:0] hdr_word,
    input  logic [LEN_W-1:0]  frame_size,
    output logic [LEN_W:0]    words_needed,
    output logic              oversize
);
    localparam int BYTES_PER_WORD = DATA_W / 8;
    localparam int SHIFT          = $clog2(BYTES_PER_WORD);

    logic [LEN_W-1:0] byte_cnt;
    logic [LEN_W:0]   rounded;

    // Round the byte count up to whole words; an empty count still needs one word.
    always_comb begin
        byte_cnt = hdr_word[LEN_LSB +: LEN_W];
        rounded  = ({1'b0, byte_cnt} + (LEN_W+1)'(BYTES_PER_WORD - 1)) >> SHIFT;
        words_needed = (rounded == '0) ? (LEN_W+1)'(1) : rounded;
        oversize = words_needed > {1'b0, frame_size};
    end
endmodule

// File: rtl/frame_counter.sv
// Module: counts the words sent in the current frame and flags the final one.
// Assumes: frame_size is at least 1 and stays the same inside a frame.
module frame_counter #(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             step,
    input  logic [LEN_W-1:0] frame_size,
    output logic [LEN_W-1:0] count,
    output logic             at_end
);
    // Final word of the frame when the count reaches size minus one.
    always_comb begin
        at_end = (count == frame_size - LEN_W'(1));
    end

    // Advance on each output word and wrap at the end of the frame.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            count <= '0;
        end else if (step) begin
            count <= at_end ? '0 : count + LEN_W'(1);
        end
    end

    AST_CNT_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_size != '0) |-> (count < frame_size)); // R2
endmodule

// File: rtl/pad_mux.sv
// Module: chooses what goes on the output: a packet word, filler, or nothing,
// and drives the input ready that goes with that choice.
// Assumes: state and reject come from the controller in the same cycle.
module pad_mux
    import chunk_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  chunk_state_t      state,
    input  logic              reject,
    input  logic              at_end,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_valid,
    input  logic              out_ready,
    output logic              in_ready,
    output logic [DATA_W-1:0] out_data,
    output logic              out_valid,
    output logic              out_last
);
    localparam logic [DATA_W-1:0] FILLER = '1;

    // Pass-through, filler or drop, chosen by the controller state.
    always_comb begin
        out_data  = in_data;
        out_valid = 1'b0;
        out_last  = 1'b0;
        in_ready  = 1'b0;
        unique case (state)
            ST_HEAD: begin
                if (reject && in_valid) begin
                    in_ready = 1'b1;
                end else begin
                    out_valid = in_valid;
                    out_last  = at_end;
                    in_ready  = out_ready;
                end
            end
            ST_BODY: begin
                out_valid = in_valid;
                out_last  = at_end;
                in_ready  = out_ready;
            end
            ST_FILL: begin
                out_data  = FILLER;
                out_valid = 1'b1;
                out_last  = at_end;
            end
            default: begin
                in_ready  = 1'b1;
            end
        endcase
    end

    AST_FILL_IS_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && !in_ready) |-> (out_data == FILLER)); // R3

    AST_FILL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FILL && !out_ready) |=> (out_valid || state != ST_FILL)); // R11
endmodule

// File: rtl/frame_pad_chunker.sv
// Module: top of the padding chunker. Sends each packet inside a frame of
// fixed word count, fills the rest with all-ones, and flags oversize packets.
// Assumes: the first word of a packet is a header with its byte count at
// [31:16]; frame_words is only sampled during reset or a clear pulse.
module frame_pad_chunker
    import chunk_pkg::*;
#(
    parameter int DATA_W  = 64,
    parameter int LEN_W   = 16,
    parameter int LEN_LSB = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic [LEN_W-1:0]  frame_words,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_last,
    input  logic              in_valid,
    output logic              in_ready,
    output logic [DATA_W-1:0] out_data,
    output logic              out_last,
    output logic              out_valid,
    input  logic              out_ready,
    output logic              err
);
    chunk_state_t     state_q;
    logic [LEN_W-1:0] frame_q;
    logic [LEN_W-1:0] frame_eff;
    logic [LEN_W:0]   words_needed;
    logic             oversize;
    logic [LEN_W-1:0] word_cnt;
    logic             at_end;
    logic             fire_in;
    logic             fire_out;
    logic             cnt_restart;

    // A frame size of zero is taken as one word.
    always_comb begin
        frame_eff = (frame_words == '0) ? LEN_W'(1) : frame_words;
    end

    hdr_len_decode #(
        .DATA_W (DATA_W),
        .LEN_W  (LEN_W),
        .LEN_LSB(LEN_LSB)
    ) u_len (
        .hdr_word    (in_data),
        .frame_size  (frame_q),
        .words_needed(words_needed),
        .oversize    (oversize)
    );

    frame_counter #(
        .LEN_W(LEN_W)
    ) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (cnt_restart),
        .step      (fire_out),
        .frame_size(frame_q),
        .count     (word_cnt),
        .at_end    (at_end)
    );

    pad_mux #(
        .DATA_W(DATA_W)
    ) u_mux (
        .clk      (clk),
        .rst_n    (rst_n),
        .state    (state_q),
        .reject   (oversize),
        .at_end   (at_end),
        .in_data  (in_data),
        .in_valid (in_valid),
        .out_ready(out_ready),
        .in_ready (in_ready),
        .out_data (out_data),
        .out_valid(out_valid),
        .out_last (out_last)
    );

    // Handshake strobes and counter restart.
    always_comb begin
        fire_in     = in_valid && in_ready;
        fire_out    = out_valid && out_ready;
        cnt_restart = clear || (state_q == ST_FAULT);
    end

    // Frame size register: loaded during reset and on a clear pulse.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            frame_q <= frame_eff;
        end
    end

    // Framing controller and sticky error flag.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            state_q <= ST_HEAD;
            err     <= 1'b0;
        end else begin
            unique case (state_q)
                ST_HEAD: begin
                    if (fire_in) begin
                        if (oversize || (at_end && !in_last)) begin
                            state_q <= ST_FAULT;
                            err     <= 1'b1;
                        end else if (in_last) begin
                            state_q <= at_end ? ST_HEAD : ST_FILL;
                        end else begin
                            state_q <= ST_BODY;
                        end
                    end
                end
                ST_BODY: begin
                    if (fire_in) begin
                        if (at_end && !in_last) begin
                            state_q <= ST_FAULT;
                            err     <= 1'b1;
                        end else if (in_last) begin
                            state_q <= at_end ? ST_HEAD : ST_FILL;
                        end
                    end
                end
                ST_FILL: begin
                    if (fire_out && at_end) begin
                        state_q <= ST_HEAD;
                    end
                end
                default: begin
                    state_q <= ST_FAULT;
                end
            endcase
        end
    end

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !clear) |=> err); // R6

    AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (!out_valid && in_ready)); // R6

    AST_CLEAR_LOWERS: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> !err); // R7

    AST_OVERSIZE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HEAD && in_valid && oversize && !clear) |=> err); // R5

    AST_OVERSIZE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HEAD && oversize) |-> !out_valid); // R5
endmodule

// File: tb/sim_frame_pad_chunker.sv
module sim_frame_pad_chunker;
    localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clear = 1'b0;
    logic [15:0] frame_words = 16'd8;
    logic [63:0] in_data = '0;
    logic        in_last = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [63:0] out_data;
    logic        out_last;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic        err;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    logic [63:0] exp_d [64];
    int          exp_n = 0;
    logic [63:0] got_d [64];
    logic        got_l [64];
    int          got_n = 0;

    always #2.5 clk = ~clk;

    frame_pad_chunker u0 (
        .clk(clk), .rst_n(rst_n), .clear(clear), .frame_words(frame_words),
        .in_data(in_data), .in_last(in_last), .in_valid(in_valid), .in_ready(in_ready),
        .out_data(out_data), .out_last(out_last), .out_valid(out_valid),
        .out_ready(out_ready), .err(err)
    );

    // Output collector: records every accepted output word.
    always @(posedge clk) begin
        if (rst_n && out_valid && out_ready && got_n < 64) begin
            got_d[got_n] = out_data;
            got_l[got_n] = out_last;
            got_n = got_n + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic start_case();
        got_n = 0;
        exp_n = 0;
    endtask

    task automatic load_frame(input logic [15:0] fw);
        @(negedge clk);
        frame_words = fw;
        clear = 1'b1;
        @(negedge clk);
        clear = 1'b0;
    endtask

    // Drive one packet; word 0 is a header carrying the byte count at [31:16].
    task automatic send_pkt(input int bytes, input int nwords, input logic [7:0] tag, input bit expect_out);
        for (int i = 0; i < nwords; i++) begin
            logic [63:0] w;
            if (i == 0) w = {16'hC0DE, tag, 8'h00, bytes[15:0], 16'h0001};
            else        w = {24'h5A5A00, tag, 32'(i)};
            @(negedge clk);
            in_data  = w;
            in_last  = (i == nwords - 1);
            in_valid = 1'b1;
            #1;
            while (!in_ready) begin
                @(negedge clk);
                #1;
            end
            @(posedge clk);
            if (expect_out) begin
                exp_d[exp_n] = w;
                exp_n++;
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_last  = 1'b0;
    endtask

    task automatic add_fill(input int n);
        for (int i = 0; i < n; i++) begin
            exp_d[exp_n] = ONES;
            exp_n++;
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Compare the collected frames with the expected words; fs is the frame size.
    task automatic check_frames(input string req, input int fs);
        chk(got_n == exp_n, req, 64'(got_n), 64'(exp_n));
        for (int i = 0; i < exp_n && i < got_n; i++) begin
            chk(got_d[i] === exp_d[i], req, got_d[i], exp_d[i]);
            chk(got_l[i] === ((i % fs) == fs - 1), {req, " last"}, 64'(got_l[i]), 64'((i % fs) == fs - 1));
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(out_valid == 1'b0, "R10 out_valid", 64'(out_valid), 64'd0);
        chk(err == 1'b0, "R10 err", 64'(err), 64'd0);
        chk(in_ready == 1'b1, "R10 in_ready", 64'(in_ready), 64'd1);
    endtask

    // R1 R2 R3: five words into an eight-word frame, in_ready low during fill.
    task automatic t_short();
        start_case();
        send_pkt(40, 5, 8'h11, 1'b1);
        chk(in_ready == 1'b0, "R3 in_ready during fill", 64'(in_ready), 64'd0);
        add_fill(3);
        idle(6);
        check_frames("R1 R2 R3 short", 8);
    endtask

    // R8: single-word packet.
    task automatic t_one();
        start_case();
        send_pkt(8, 1, 8'h22, 1'b1);
        add_fill(7);
        idle(10);
        check_frames("R8 one word", 8);
    endtask

    // R4: exact fit, no filler.
    task automatic t_exact();
        load_frame(16'd5);
        start_case();
        send_pkt(40, 5, 8'h33, 1'b1);
        idle(4);
        check_frames("R4 exact", 5);
        chk(err == 1'b0, "R4 err", 64'(err), 64'd0);
    endtask

    // R5: 33 bytes round up to 5 words, fits a five-word frame.
    task automatic t_round();
        start_case();
        send_pkt(33, 5, 8'h44, 1'b1);
        idle(4);
        check_frames("R5 rounding", 5);
        chk(err == 1'b0, "R5 no err", 64'(err), 64'd0);
    endtask

    // R5 R6: 48 bytes (6 words) into a five-word frame, then more input while flagged.
    task automatic t_over();
        start_case();
        send_pkt(48, 6, 8'h55, 1'b0);
        idle(2);
        chk(err == 1'b1, "R5 err raised", 64'(err), 64'd1);
        chk(got_n == 0, "R5 nothing sent", 64'(got_n), 64'd0);
        send_pkt(16, 2, 8'h56, 1'b0);
        chk(in_ready == 1'b1, "R6 in_ready while err", 64'(in_ready), 64'd1);
        idle(4);
        chk(err == 1'b1, "R6 err sticky", 64'(err), 64'd1);
        chk(got_n == 0, "R6 dropped", 64'(got_n), 64'd0);
    endtask

    // R7: clear lowers err and loads a three-word frame.
    task automatic t_clear();
        load_frame(16'd3);
        chk(err == 1'b0, "R7 err cleared", 64'(err), 64'd0);
        start_case();
        send_pkt(16, 2, 8'h66, 1'b1);
        add_fill(1);
        idle(4);
        check_frames("R7 new frame size", 3);
    endtask

    // R9: back-to-back packets of 2, 4 and 1 words in four-word frames.
    task automatic t_b2b();
        load_frame(16'd4);
        start_case();
        send_pkt(16, 2, 8'h71, 1'b1);
        add_fill(2);
        send_pkt(32, 4, 8'h72, 1'b1);
        send_pkt(8, 1, 8'h73, 1'b1);
        add_fill(3);
        idle(6);
        check_frames("R9 back to back", 4);
    endtask

    // R11: backpressure in the middle of the filler of a six-word frame.
    task automatic t_stall();
        load_frame(16'd6);
        start_case();
        send_pkt(8, 1, 8'h81, 1'b1);
        add_fill(5);
        @(negedge clk);
        out_ready = 1'b0;
        idle(3);
        chk(out_valid == 1'b1, "R11 valid held", 64'(out_valid), 64'd1);
        chk(out_data == ONES, "R11 data held", out_data, ONES);
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
        idle(2);
        out_ready = 1'b1;
        idle(10);
        check_frames("R11 stall", 6);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_short();
        t_one();
        t_exact();
        t_round();
        t_over();
        t_clear();
        t_b2b();
        t_stall();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        #500000;
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end
endmodule